// File: doc/BRIEF.md
# Synchronous-Terminate Memory Responder

This block sits on the memory side of a synchronous processor bus. It holds a small word-wide memory array and answers each bus cycle itself. The processor starts a cycle by raising the cycle strobe with a valid address and direction. After a fixed number of wait clocks, the responder raises a one-clock terminate pulse. Read data is driven onto the data bus only during that terminate clock. Writes are committed on the clock edge that closes the terminate clock, using the clock alone and not a data strobe.

A write is committed only if the cycle strobe is still high at that edge. A cycle that the processor abandons therefore changes nothing. A configurable address window is reported as non-cacheable, on a flag that rises in the same clock as terminate. Transfers are always full words, and the size inputs do not affect the result. Once a cycle has been terminated, the responder ignores the bus until it has seen the strobe low, so one strobe assertion can never receive two terminates.

Top module: `sync_term_mem_slave`

## Requirements
- R1: While `rst_n` is low and in the first clock after it, `term`, `nocache` and `rdata_oe` are 0 and `rdata` is all zeros.
- R2: Let E0 be the rising edge at which the responder is armed and first samples `cyc_strobe` high. Then `term` is high in the clock that follows edge E0+WAITS and low in every clock before it. WAITS is 0 to 7; a value of 0 gives a two-clock cycle.
- R3: `term` is high for exactly one clock per cycle, so it is low again within two clocks of its assertion.
- R4: `nocache` is high exactly when `term` is high and the address sampled at E0 lies in the half-open range [NC_BASE, NC_LIMIT).
- R5: For a read (`rd_nwr`=1), `rdata_oe` is high and `rdata` carries the stored word during the terminate clock only. At all other times `rdata_oe` is 0 and `rdata` is zero.
- R6: Address bits [9:2] pick one of 256 words. A write (`rd_nwr`=0) stores `wdata` at the rising edge that ends the terminate clock. A later read of the same word returns that value.
- R7: If `cyc_strobe` is low at the rising edge that ends the terminate clock, the write is dropped and the word keeps its old value.
- R8: If `cyc_strobe` falls during the wait clocks, no terminate is issued and nothing is written.
- R9: After reset, and after every terminate, no new cycle is accepted until `cyc_strobe` has been sampled low. A strobe held high gets no second `term`.
- R10: `xfer_size` has no effect on timing, data or the non-cacheable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_strobe | input | 1 | High while the processor holds a valid cycle |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| xfer_size | input | 2 | Transfer size, ignored |
| term | output | 1 | Synchronous terminate pulse |
| nocache | output | 1 | Non-cacheable flag, valid with `term` |
| rdata | output | DATA_W | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data is being driven |

## Verification
The assertions check on every clock the properties that hold cycle by cycle. Terminate never lasts two clocks. The non-cacheable flag and the read-data enable never appear without terminate. A strobe dropped during the wait clocks never leads to a terminate. A strobe still held after a terminate never gets a second one. Other behaviours need the bench's scenarios, because they depend on data and history: the exact wait count from the strobe to terminate, the contents of every word after a full write sweep and read-back, the loss of a write whose strobe was pulled during terminate, and the exact edges of the non-cacheable window.

// File: rtl/sync_term_mem_slave.sv
module sync_term_mem_slave #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 8,
  parameter int IDX_LSB = 2,
  parameter int WAITS   = 2,
  parameter logic [ADDR_W-1:0] NC_BASE  = 'h300,
  parameter logic [ADDR_W-1:0] NC_LIMIT = 'h380
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_strobe,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        xfer_size,
  output logic              term,
  output logic              nocache,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = (WAITS > 1) ? $clog2(WAITS) : 1;

  typedef enum logic [1:0] {ST_REARM, ST_IDLE, ST_WAIT, ST_TERM} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx_q;
  logic             rd_q, nc_q;
  logic [DATA_W-1:0] mem [DEPTH];

  wire in_nc     = (addr >= NC_BASE) && (addr < NC_LIMIT);
  wire mem_we    = (st == ST_TERM) && !rd_q && cyc_strobe;
  wire unused_sz = &{1'b0, xfer_size};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_REARM;
      cnt   <= '0;
      idx_q <= '0;
      rd_q  <= 1'b0;
      nc_q  <= 1'b0;
    end else begin
      case (st)
        ST_REARM: if (!cyc_strobe) st <= ST_IDLE;
        ST_IDLE: if (cyc_strobe) begin
          idx_q <= addr[IDX_LSB +: IDX_W];
          rd_q  <= rd_nwr;
          nc_q  <= in_nc;
          if (WAITS == 0) st <= ST_TERM;
          else begin
            st  <= ST_WAIT;
            cnt <= CNT_W'(WAITS - 1);
          end
        end
        ST_WAIT: begin
          if (!cyc_strobe)   st <= ST_IDLE;
          else if (cnt == 0) st <= ST_TERM;
          else               cnt <= cnt - 1'b1;
        end
        default: st <= cyc_strobe ? ST_REARM : ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (mem_we) mem[idx_q] <= wdata;

  assign term     = (st == ST_TERM);
  assign nocache  = term && nc_q;
  assign rdata_oe = term && rd_q;
  assign rdata    = rdata_oe ? mem[idx_q] : '0;

  p_term_one_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> !term);
  p_nc_only_with_term_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nocache |-> term);
  p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> !rdata_oe);
  p_abort_no_term_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !cyc_strobe) |=> !term);
  p_held_strobe_no_retrigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (term && cyc_strobe) |=> (cyc_strobe |=> !term));
  p_term_follows_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term) |-> $past(cyc_strobe));
endmodule

// File: tb/tb_sync_term_mem_slave.sv
module tb_sync_term_mem_slave;
  localparam int TW = 2;
  localparam logic [31:0] NCB = 32'h300;
  localparam logic [31:0] NCL = 32'h380;

  logic clk = 0, rst_n = 0, cyc_strobe = 0, rd_nwr = 0;
  logic [31:0] addr = 0, wdata = 0;
  logic [1:0] xfer_size = 0;
  logic term, nocache, rdata_oe;
  logic [31:0] rdata;

  sync_term_mem_slave #(.WAITS(TW), .NC_BASE(NCB), .NC_LIMIT(NCL)) dut (
    .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .rd_nwr(rd_nwr),
    .addr(addr), .wdata(wdata), .xfer_size(xfer_size), .term(term),
    .nocache(nocache), .rdata(rdata), .rdata_oe(rdata_oe));

  always #5 clk = ~clk;

  int errs = 0, checks = 0;
  logic [31:0] model [256];
  logic [31:0] got;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int salt);
    return (32'(i) * 32'h9E3779B1) ^ (32'(salt) << 8) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] adr(input int i);
    return {22'h0, 8'(i), 2'b00} | (i[0] ? 32'h0001_0000 : 32'h0);
  endfunction

  task automatic bus(input logic [31:0] a, input bit rd, input logic [31:0] wd,
                     input bit abort_term, input int extra, output logic [31:0] r);
    bit ncx;
    ncx = (a >= NCB) && (a < NCL);
    r = '0;
    @(negedge clk);
    cyc_strobe = 1; addr = a; rd_nwr = rd; wdata = wd; xfer_size = a[3:2]; // R10 varied size
    for (int k = 0; k <= TW; k++) begin
      @(negedge clk);
      if (k < TW) chk(term == 0, "R2 early term", 32'(term), 0);
      else begin
        chk(term == 1, "R2 term timing", 32'(term), 1);
        chk(nocache == ncx, "R4 nocache", 32'(nocache), 32'(ncx));
        chk(rdata_oe == rd, "R5 oe in term", 32'(rdata_oe), 32'(rd));
        r = rdata;
        if (abort_term) cyc_strobe = 0;
      end
    end
    @(negedge clk);
    chk(term == 0, "R3 term one clock", 32'(term), 0);
    chk(rdata_oe == 0 && rdata == 0, "R5 released", rdata, 0);
    for (int k = 0; k < extra; k++) begin
      @(negedge clk);
      chk(term == 0, "R9 no retrigger", 32'(term), 0);
    end
    cyc_strobe = 0;
  endtask

  initial begin
    #(150000 * 10);
    errs++;
    $display("FAIL watchdog actual=%h expected=%h", 32'(1), 32'(0));
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    cyc_strobe = 1;
    repeat (3) @(negedge clk);
    chk(term == 0 && nocache == 0 && rdata_oe == 0 && rdata == 0, "R1 reset", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    chk(term == 0 && nocache == 0 && rdata_oe == 0 && rdata == 0, "R1 after reset", rdata, 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(term == 0, "R9 strobe high from reset", 32'(term), 0);
    end
    cyc_strobe = 0;

    for (int i = 0; i < 256; i++) begin   // R6 full write sweep
      model[i] = pat(i, 1);
      bus(adr(i), 0, model[i], 0, 0, got);
    end
    for (int i = 0; i < 256; i++) begin   // R5 R6 read back
      bus(adr(i), 1, 0, 0, 0, got);
      chk(got == model[i], "R6 read back", got, model[i]);
    end

    bus(adr(5), 0, 32'hDEAD_BEEF, 1, 0, got);   // R7 strobe pulled in term
    bus(adr(5), 1, 0, 0, 0, got);
    chk(got == model[5], "R7 aborted write", got, model[5]);

    @(negedge clk);                              // R8 strobe pulled while waiting
    cyc_strobe = 1; addr = adr(6); rd_nwr = 0; wdata = 32'hCAFE_F00D;
    @(negedge clk);
    cyc_strobe = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(term == 0, "R8 no term after drop", 32'(term), 0);
    end
    bus(adr(6), 1, 0, 0, 0, got);
    chk(got == model[6], "R8 no write after drop", got, model[6]);

    model[7] = 32'h1234_5678;                    // R9 strobe held long after term
    bus(adr(7), 0, model[7], 0, 6, got);
    bus(adr(7), 1, 0, 0, 4, got);
    chk(got == model[7], "R9 data after long hold", got, model[7]);

    for (int i = 190; i < 226; i++) begin        // R4 window edges, R10 other sizes
      model[i] = pat(i, 2);
      bus({22'h0, 8'(i), 2'b00}, 0, model[i], 0, 0, got);
      bus({22'h0, 8'(i), 2'b00}, 1, 0, 0, 0, got);
      chk(got == model[i], "R10 data regardless of size", got, model[i]);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule